// File: doc/BRIEF.md
# Scrolling Tile Background Fetcher

This block turns a beam position into a stream of background pixel words for a tile-mapped playfield that scrolls sideways. Each tile is 24 pixels wide and 16 lines tall and is read as four columns of six pixels. On every slot strobe, which comes once per microsecond in the intended system, the block adds a horizontal scroll offset to the column position. It forms an address into an external 2048-byte tile map, then reads back a byte that holds a 7-bit tile code and a mirror bit. From that byte it builds a 13-bit address into an external graphics store. The store is three byte-wide memories read side by side, so it returns 24 bits, which are six 4-bit pixels.

Both external memories are synchronous and return data one clock after their address. The block registers every stage, so a new slot can start on every clock. When the mirror bit of a tile is set, the block reads that tile's pixel columns in reverse order and reverses the six pixels inside each fetched word. The finished word appears with a one-cycle valid pulse a fixed number of clocks after its strobe. Writing the tile map and looking up colours belong to neighbouring blocks.

Top module: `bgf_fetch`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pix_valid` is 0 and `pix_word`, `map_addr` and `gfx_addr` are all zero.
- R2: On the clock edge where `slot_en` is 1, `map_addr` is loaded with {`vpos[7:4]`, column}. The column is bits [8:2] of the 9-bit column sum `hpos + scroll`, and it takes `map_addr[6:0]`.
- R3: The column sum wraps modulo 512, so the map column wraps modulo 128 tiles. For example, `hpos`=63 and `scroll`=511 give column sum 62, which is tile column 15 and column group 2.
- R4: Two edges after a strobe, `gfx_addr` is loaded with {code, `vpos[3:0]`, group}. The code is `map_data[6:0]` and takes bits [12:6]. The row takes bits [5:2] and the group takes bits [1:0]. The group is the column sum's bits [1:0] when `map_data[7]` is 0, and 3 minus that value when `map_data[7]` is 1.
- R5: `pix_valid` is 1 for exactly one cycle, four edges after the strobe edge, and `pix_word` is updated on that same edge. Strobes on consecutive cycles produce valid words on consecutive cycles, in the same order.
- R6: When the tile's mirror bit (`map_data[7]`) is 0, `pix_word` equals the `gfx_data` returned for that slot. The leftmost pixel is `pix_word[23:20]` and the rightmost is `pix_word[3:0]`.
- R7: When the mirror bit is 1, pixel k of `pix_word` is pixel 5-k of `gfx_data`. The mirror bit stays paired with its own slot when strobes are back to back.
- R8: When `slot_en` is 0, changes on `hpos`, `vpos` and `scroll` have no effect: `map_addr` and `pix_word` hold and no valid pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_en | input | 1 | Fetch strobe, one per pixel slot |
| hpos | input | 6 | Screen column position: tile column [5:2], column group [1:0] |
| vpos | input | 8 | Screen line: tile row [7:4], line within tile [3:0] |
| scroll | input | 9 | Horizontal scroll offset in 6-pixel column groups |
| map_addr | output | 11 | Tile map read address |
| map_data | input | 8 | Tile map byte, one clock after its address: mirror bit [7], code [6:0] |
| gfx_addr | output | 13 | Graphics store read address |
| gfx_data | input | 24 | Graphics word, one clock after its address |
| pix_word | output | 24 | Six 4-bit pixels, leftmost in [23:20] |
| pix_valid | output | 1 | One-cycle pulse when `pix_word` is updated |

## Verification
The hardest case to reach is a mirrored tile that sits right at the 512-group wrap point while strobes arrive back to back. In that case the mirror bit, the reversed column group and the reversed word must all stay paired with the right slot as they pass through the pipeline. The stimulus sets `hpos` and `scroll` so that their sum wraps. It then fires strobes in bursts with no idle cycles between them, and it uses a map model whose mirror bit follows the address parity, so both mirrored and plain tiles land in each burst. A random phase then mixes gaps and bursts, and it counts how many mirrored words came out so that the mirror case is known to have occurred.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
    localparam int GRP_W     = 2;   // column groups per tile (log2)
    localparam int VCOL_W    = 4;   // visible tile columns (log2)
    localparam int MCOL_W    = 7;   // map tile columns (log2)
    localparam int VTILE_W   = 4;   // tile rows (log2)
    localparam int ROW_W     = 4;   // lines per tile (log2)
    localparam int CODE_W    = 7;   // tile code width
    localparam int PIX_N     = 6;   // pixels per fetched word
    localparam int NIB_W     = 4;   // bits per pixel

    localparam int HPOS_W    = VCOL_W + GRP_W;
    localparam int SCROLL_W  = MCOL_W + GRP_W;
    localparam int VPOS_W    = VTILE_W + ROW_W;
    localparam int MAP_AW    = VTILE_W + MCOL_W;
    localparam int MAP_DW    = CODE_W + 1;
    localparam int GFX_AW    = CODE_W + ROW_W + GRP_W;
    localparam int WORD_W    = PIX_N * NIB_W;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [GRP_W-1:0] grp;
    } sub_t;

    typedef struct packed {
        logic              mirror;
        logic [CODE_W-1:0] code;
    } entry_t;

    function automatic logic [WORD_W-1:0] mirror_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < PIX_N; i++)
            r[i*NIB_W +: NIB_W] = w[(PIX_N-1-i)*NIB_W +: NIB_W];
        return r;
    endfunction
endpackage

// File: rtl/bgf_locate.sv
module bgf_locate
    import bgf_pkg::*;
(
    input  logic [HPOS_W-1:0]   hpos,
    input  logic [VPOS_W-1:0]   vpos,
    input  logic [SCROLL_W-1:0] scroll,
    output logic [MAP_AW-1:0]   map_addr_nx,
    output sub_t                sub_nx
);
    logic [SCROLL_W-1:0] col_sum;

    always_comb begin
        col_sum     = SCROLL_W'(hpos) + scroll;   // wraps modulo map width
        map_addr_nx = {vpos[VPOS_W-1 -: VTILE_W], col_sum[SCROLL_W-1:GRP_W]};
        sub_nx.row  = vpos[ROW_W-1:0];
        sub_nx.grp  = col_sum[GRP_W-1:0];
    end
endmodule

// File: rtl/bgf_tile_addr.sv
module bgf_tile_addr
    import bgf_pkg::*;
(
    input  entry_t              entry,
    input  sub_t                sub,
    output logic [GFX_AW-1:0]   gfx_addr_nx
);
    logic [GRP_W-1:0] grp_eff;

    always_comb begin
        grp_eff     = entry.mirror ? ~sub.grp : sub.grp;
        gfx_addr_nx = {entry.code, sub.row, grp_eff};
    end
endmodule

// File: rtl/bgf_nibble_flip.sv
module bgf_nibble_flip
    import bgf_pkg::*;
(
    input  logic              mirror,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    for (genvar i = 0; i < PIX_N; i++) begin : g_pix
        assign dout[i*NIB_W +: NIB_W] = mirror ? din[(PIX_N-1-i)*NIB_W +: NIB_W]
                                               : din[i*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/bgf_fetch.sv
module bgf_fetch
    import bgf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                slot_en,
    input  logic [HPOS_W-1:0]   hpos,
    input  logic [VPOS_W-1:0]   vpos,
    input  logic [SCROLL_W-1:0] scroll,
    output logic [MAP_AW-1:0]   map_addr,
    input  logic [MAP_DW-1:0]   map_data,
    output logic [GFX_AW-1:0]   gfx_addr,
    input  logic [WORD_W-1:0]   gfx_data,
    output logic [WORD_W-1:0]   pix_word,
    output logic                pix_valid
);
    logic [MAP_AW-1:0] map_addr_nx;
    sub_t              sub_nx, sub_a, sub_b;
    logic              vld_a, vld_b, vld_c, vld_d;
    logic              mir_c, mir_d;
    logic [GFX_AW-1:0] gfx_addr_nx;
    logic [WORD_W-1:0] word_nx;
    entry_t            entry;

    assign entry = entry_t'(map_data);

    bgf_locate u_locate (
        .hpos        (hpos),
        .vpos        (vpos),
        .scroll      (scroll),
        .map_addr_nx (map_addr_nx),
        .sub_nx      (sub_nx)
    );

    bgf_tile_addr u_tile_addr (
        .entry       (entry),
        .sub         (sub_b),
        .gfx_addr_nx (gfx_addr_nx)
    );

    bgf_nibble_flip u_flip (
        .mirror (mir_d),
        .din    (gfx_data),
        .dout   (word_nx)
    );

    // stage A: map address issue
    always_ff @(posedge clk) begin
        if (rst) begin
            map_addr <= '0;
            sub_a    <= '0;
            vld_a    <= 1'b0;
        end else begin
            vld_a <= slot_en;
            if (slot_en) begin
                map_addr <= map_addr_nx;
                sub_a    <= sub_nx;
            end
        end
    end

    // stage B: map read in flight
    always_ff @(posedge clk) begin
        if (rst) begin
            sub_b <= '0;
            vld_b <= 1'b0;
        end else begin
            vld_b <= vld_a;
            if (vld_a) sub_b <= sub_a;
        end
    end

    // stage C: graphics address issue
    always_ff @(posedge clk) begin
        if (rst) begin
            gfx_addr <= '0;
            mir_c    <= 1'b0;
            vld_c    <= 1'b0;
        end else begin
            vld_c <= vld_b;
            if (vld_b) begin
                gfx_addr <= gfx_addr_nx;
                mir_c    <= entry.mirror;
            end
        end
    end

    // stage D: graphics read in flight
    always_ff @(posedge clk) begin
        if (rst) begin
            mir_d <= 1'b0;
            vld_d <= 1'b0;
        end else begin
            vld_d <= vld_c;
            if (vld_c) mir_d <= mir_c;
        end
    end

    // output word
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_word  <= '0;
            pix_valid <= 1'b0;
        end else begin
            pix_valid <= vld_d;
            if (vld_d) pix_word <= word_nx;
        end
    end
endmodule

// File: rtl/bgf_fetch_checker.sv
module bgf_fetch_checker
    import bgf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                slot_en,
    input logic [VPOS_W-1:0]   vpos,
    input logic [MAP_AW-1:0]   map_addr,
    input logic [MAP_DW-1:0]   map_data,
    input logic [GFX_AW-1:0]   gfx_addr,
    input logic [WORD_W-1:0]   gfx_data,
    input logic [WORD_W-1:0]   pix_word,
    input logic                pix_valid
);
    AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(slot_en, 5)); // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> $stable(pix_word)); // R8

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(slot_en) |-> $stable(map_addr)); // R8

    AST_MAP_ROW: assert property (@(posedge clk) disable iff (rst)
        $past(slot_en) |-> map_addr[MAP_AW-1 -: VTILE_W] == $past(vpos[VPOS_W-1 -: VTILE_W])); // R2

    AST_GFX_ROW: assert property (@(posedge clk) disable iff (rst)
        $past(slot_en, 3) |-> gfx_addr[GRP_W +: ROW_W] == $past(vpos[ROW_W-1:0], 3)); // R4

    AST_WORD_ORDER: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> pix_word == ($past(map_data[MAP_DW-1], 3) ? mirror_word($past(gfx_data))
                                                                 : $past(gfx_data))); // R7
endmodule

bind bgf_fetch bgf_fetch_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_en   (slot_en),
    .vpos      (vpos),
    .map_addr  (map_addr),
    .map_data  (map_data),
    .gfx_addr  (gfx_addr),
    .gfx_data  (gfx_data),
    .pix_word  (pix_word),
    .pix_valid (pix_valid)
);

// File: tb/bgf_fetch_test.sv
module bgf_fetch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_en = 1'b0;
    logic [5:0]  hpos = '0;
    logic [7:0]  vpos = '0;
    logic [8:0]  scroll = '0;
    logic [10:0] map_addr;
    logic [7:0]  map_data = '0;
    logic [12:0] gfx_addr;
    logic [23:0] gfx_data = '0;
    logic [23:0] pix_word;
    logic        pix_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mirrored_seen = 0;
    bit done = 1'b0;

    logic [23:0] exp_word_q[$];
    int          exp_cyc_q[$];
    bit          exp_mir_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bgf_fetch uut (
        .clk(clk), .rst(rst), .slot_en(slot_en), .hpos(hpos), .vpos(vpos),
        .scroll(scroll), .map_addr(map_addr), .map_data(map_data),
        .gfx_addr(gfx_addr), .gfx_data(gfx_data), .pix_word(pix_word),
        .pix_valid(pix_valid)
    );

    function automatic logic [7:0] map_rom(input logic [10:0] a);
        return {^a, a[6:0] ^ a[10:4]};
    endfunction

    function automatic logic [23:0] gfx_rom(input logic [12:0] a);
        logic [23:0] x;
        x = {11'd0, a} * 24'd40503;
        return x ^ {a[10:0], a} ^ 24'h5A3C96;
    endfunction

    function automatic logic [23:0] rev6(input logic [23:0] w);
        logic [23:0] r;
        for (int i = 0; i < 6; i++) r[i*4 +: 4] = w[(5-i)*4 +: 4];
        return r;
    endfunction

    function automatic logic [10:0] exp_map(input logic [5:0] h, input logic [7:0] v, input logic [8:0] s);
        logic [8:0] sum;
        sum = {3'd0, h} + s;
        return {v[7:4], sum[8:2]};
    endfunction

    function automatic logic [12:0] exp_gfx(input logic [5:0] h, input logic [7:0] v, input logic [8:0] s);
        logic [8:0] sum;
        logic [7:0] md;
        logic [1:0] g;
        sum = {3'd0, h} + s;
        md  = map_rom(exp_map(h, v, s));
        g   = md[7] ? 2'd3 - sum[1:0] : sum[1:0];
        return {md[6:0], v[3:0], g};
    endfunction

    // synchronous memory models
    always @(posedge clk) begin
        map_data <= map_rom(map_addr);
        gfx_data <= gfx_rom(gfx_addr);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // drive one strobe at a falling edge; returns at the next falling edge
    task automatic issue(input logic [5:0] h, input logic [7:0] v, input logic [8:0] s);
        logic [23:0] w;
        logic [7:0]  md;
        md = map_rom(exp_map(h, v, s));
        w  = gfx_rom(exp_gfx(h, v, s));
        hpos = h; vpos = v; scroll = s; slot_en = 1'b1;
        exp_word_q.push_back(md[7] ? rev6(w) : w);
        exp_mir_q.push_back(md[7]);
        exp_cyc_q.push_back(cyc + 5);
        @(negedge clk);
        check(map_addr == exp_map(h, v, s), "R2/R3 map_addr", 32'(map_addr), 32'(exp_map(h, v, s)));
    endtask

    task automatic idle(input int n);
        slot_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst && pix_valid) begin
            if (exp_word_q.size() == 0) begin
                check(1'b0, "R5/R8 unexpected pix_valid", 32'(pix_word), 32'd0);
            end else begin
                logic [23:0] ew;
                int          ec;
                bit          em;
                ew = exp_word_q.pop_front();
                ec = exp_cyc_q.pop_front();
                em = exp_mir_q.pop_front();
                if (em) mirrored_seen++;
                check(cyc == ec, "R5 latency", 32'(cyc), 32'(ec));
                check(pix_word == ew, em ? "R7 mirrored word" : "R6 plain word", 32'(pix_word), 32'(ew));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] ma_hold;
        logic [23:0] pw_hold;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0, "R1 pix_valid in reset", 32'(pix_valid), 0);
        check(pix_word == '0, "R1 pix_word in reset", 32'(pix_word), 0);
        check(map_addr == '0, "R1 map_addr in reset", 32'(map_addr), 0);
        check(gfx_addr == '0, "R1 gfx_addr in reset", 32'(gfx_addr), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pix_valid == 1'b0 && pix_word == '0, "R1 after reset", 32'(pix_word), 0);

        // R2/R4: single strobe, no scroll
        issue(6'd9, 8'h5B, 9'd0);
        idle(2);
        check(gfx_addr == exp_gfx(6'd9, 8'h5B, 9'd0), "R4 gfx_addr", 32'(gfx_addr), 32'(exp_gfx(6'd9, 8'h5B, 9'd0)));
        idle(4);

        // R3: wrap at the seam (63 + 511 -> 62)
        issue(6'd63, 8'h21, 9'd511);
        check(map_addr[6:0] == 7'd15, "R3 wrapped column", 32'(map_addr[6:0]), 15);
        idle(2);
        check(gfx_addr == exp_gfx(6'd63, 8'h21, 9'd511), "R4 gfx_addr wrapped", 32'(gfx_addr), 32'(exp_gfx(6'd63, 8'h21, 9'd511)));
        idle(4);

        // R4/R7: scan all four groups of a few tiles, mirror set and clear
        for (int t = 0; t < 8; t++) begin
            for (int g = 0; g < 4; g++) begin
                issue(6'(t*4 + g), 8'(t*16 + 3), 9'(t*3));
                idle(2);
                check(gfx_addr == exp_gfx(6'(t*4 + g), 8'(t*16 + 3), 9'(t*3)), "R4 group order",
                      32'(gfx_addr), 32'(exp_gfx(6'(t*4 + g), 8'(t*16 + 3), 9'(t*3))));
                idle(3);
            end
        end

        // R5/R7: back-to-back burst across the seam
        for (int i = 0; i < 16; i++) issue(6'(56 + i), 8'(i*7), 9'd500);
        idle(8);

        // R8: inputs toggle with no strobe
        ma_hold = map_addr;
        pw_hold = pix_word;
        for (int i = 0; i < 10; i++) begin
            hpos = 6'($urandom); vpos = 8'($urandom); scroll = 9'($urandom);
            @(negedge clk);
        end
        check(map_addr == ma_hold, "R8 map_addr held", 32'(map_addr), 32'(ma_hold));
        check(pix_word == pw_hold, "R8 pix_word held", 32'(pix_word), 32'(pw_hold));

        // random phase: mixed bursts and gaps
        for (int i = 0; i < 400; i++) begin
            issue(6'($urandom), 8'($urandom), 9'($urandom));
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        end
        idle(10);

        check(exp_word_q.size() == 0, "R5 all words delivered", 32'(exp_word_q.size()), 0);
        check(mirrored_seen > 0, "R7 mirrored slots seen", 32'(mirrored_seen), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule